// File: doc/BRIEF.md
# Multiplexed Seven-Segment Scan Driver

This block lights eight seven-segment digits that share one segment bus. A host stores a 4-bit BCD value and a dot flag per digit through a simple write port that carries a digit index. The block turns each stored value into a segment pattern and scans the positions one at a time. A prescaler sets how long each step of the scan lasts.

Each position is shown for one prescaler tick and then blanked for one tick, to avoid ghosting. After that the select moves to the next position. Both outputs are registered and change only on a tick. A build parameter selects the output polarity for common-cathode or common-anode displays, and it applies to the segment lines and the select lines alike.

Top module: `seg_scan_top`

## Requirements
- R1: While reset is held, and until the first tick after it, every segment is off and the select enables position 7. Every stored digit resets to BCD code 15 (blank) with its dot cleared.
- R2: Exactly one select line is active in every cycle.
- R3: Segment bit 0 drives a, bits 1 to 6 drive b to g, and bit 7 drives the dot h. For BCD 0 to 9 the active-high a..g pattern (hex, bit 7 clear) is 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R4: BCD codes 10 to 15 turn every segment off, the dot included.
- R5: A position is shown for one tick. The next tick blanks all segments and leaves the select where it is. Only the tick after that moves the select on.
- R6: Positions are scanned in ascending order from 0 to 7, and the scan wraps from 7 back to 0.
- R7: A tick occurs on every PRESCALE-th rising clock edge after reset is released. The outputs change on no other edge.
- R8: The pattern for a position is captured from storage on the edge that moves the select to it. A write that lands on that same edge shows up only on the next visit, and a write during the visit leaves the current pattern unchanged.
- R9: With COMMON_ANODE set, both the segment output and the select output are the bitwise inverse of the common-cathode levels.
- R10: For BCD 0 to 9, the stored dot flag drives segment bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Store one digit this cycle |
| wr_idx_i | input | $clog2(NUM_DIGITS) | Position written |
| wr_bcd_i | input | 4 | BCD value written |
| wr_dot_i | input | 1 | Dot flag written |
| seg_o | output | 8 | Segment lines a..g, h (polarity per COMMON_ANODE) |
| sel_o | output | NUM_DIGITS | One-hot position select (polarity per COMMON_ANODE) |

## Verification
A host write and the tick that loads the same position can land on the same rising edge. That edge decides whether the old value or the new one is shown. The bench watches its own scan model and drives a write into the position that is about to be loaded on exactly that edge. It then expects the old pattern for the whole visit and the new one on the following pass. A second case writes to the position on display in the middle of its visit, and the outputs must stay unchanged until the next tick.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  localparam int SEG_W = 8;

  typedef struct packed {
    logic       dot;
    logic [3:0] bcd;
  } digit_t;

  typedef enum logic {PH_BLANK = 1'b0, PH_SHOW = 1'b1} phase_e;

  localparam digit_t DIGIT_RST = '{dot: 1'b0, bcd: 4'hF};
endpackage

// File: rtl/seg_scan_prescaler.sv
module seg_scan_prescaler #(
  parameter int PRESCALE = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/seg_scan_regfile.sv
module seg_scan_regfile
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  localparam int IDX_W = $clog2(NUM_DIGITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  digit_t           wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output digit_t           rd_data_o
);
  digit_t mem_q [NUM_DIGITS];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= DIGIT_RST;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g))) mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/seg_scan_decoder.sv
module seg_scan_decoder
  import seg_scan_pkg::*;
(
  input  digit_t           digit_i,
  output logic [SEG_W-1:0] seg_o
);
  logic [6:0] glyph;

  always_comb begin
    unique case (digit_i.bcd)
      4'd0:    glyph = 7'h3F;
      4'd1:    glyph = 7'h06;
      4'd2:    glyph = 7'h5B;
      4'd3:    glyph = 7'h4F;
      4'd4:    glyph = 7'h66;
      4'd5:    glyph = 7'h6D;
      4'd6:    glyph = 7'h7D;
      4'd7:    glyph = 7'h07;
      4'd8:    glyph = 7'h7F;
      4'd9:    glyph = 7'h6F;
      default: glyph = 7'h00;
    endcase
  end

  // codes above 9 also suppress the dot
  assign seg_o = (digit_i.bcd > 4'd9) ? '0 : {digit_i.dot, glyph};
endmodule

// File: rtl/seg_scan_sequencer.sv
module seg_scan_sequencer
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  localparam int IDX_W = $clog2(NUM_DIGITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output phase_e           phase_o,
  output logic [IDX_W-1:0] idx_o,
  output phase_e           phase_nxt_o,
  output logic [IDX_W-1:0] idx_nxt_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_DIGITS - 1);

  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    phase_nxt_o = phase_q;
    idx_nxt_o   = idx_q;
    if (tick_i) begin
      if (phase_q == PH_SHOW) begin
        phase_nxt_o = PH_BLANK;
      end else begin
        phase_nxt_o = PH_SHOW;
        idx_nxt_o   = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_BLANK;
      idx_q   <= IDX_LAST;
    end else begin
      phase_q <= phase_nxt_o;
      idx_q   <= idx_nxt_o;
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;

  assert_blank_holds_sel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && phase_q == PH_SHOW) |=> (phase_q == PH_BLANK) && $stable(idx_q));

  assert_scan_ascending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && phase_q == PH_BLANK) |=>
      (idx_q == (($past(idx_q) == IDX_LAST) ? '0 : $past(idx_q) + 1'b1)));
endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS   = 8,
  parameter int PRESCALE     = 50000,
  parameter bit COMMON_ANODE = 1'b0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [$clog2(NUM_DIGITS)-1:0] wr_idx_i,
  input  logic [3:0]                    wr_bcd_i,
  input  logic                          wr_dot_i,
  output logic [SEG_W-1:0]              seg_o,
  output logic [NUM_DIGITS-1:0]         sel_o
);
  localparam int IDX_W = $clog2(NUM_DIGITS);
  localparam logic [NUM_DIGITS-1:0] SEL_RST = NUM_DIGITS'(1) << (NUM_DIGITS - 1);

  logic             tick;
  phase_e           phase, phase_nxt;
  logic [IDX_W-1:0] idx, idx_nxt;
  digit_t           rd_digit;
  logic [SEG_W-1:0] seg_dec;
  logic [NUM_DIGITS-1:0] sel_dec;
  logic [SEG_W-1:0]      seg_hi_q;
  logic [NUM_DIGITS-1:0] sel_hi_q;

  seg_scan_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  seg_scan_sequencer #(.NUM_DIGITS(NUM_DIGITS)) u_seq (
    .clk_i, .rst_ni,
    .tick_i     (tick),
    .phase_o    (phase),
    .idx_o      (idx),
    .phase_nxt_o(phase_nxt),
    .idx_nxt_o  (idx_nxt)
  );

  seg_scan_regfile #(.NUM_DIGITS(NUM_DIGITS)) u_rf (
    .clk_i, .rst_ni,
    .wr_en_i,
    .wr_idx_i,
    .wr_data_i('{dot: wr_dot_i, bcd: wr_bcd_i}),
    .rd_idx_i (idx_nxt),
    .rd_data_o(rd_digit)
  );

  seg_scan_decoder u_dec (
    .digit_i(rd_digit),
    .seg_o  (seg_dec)
  );

  always_comb begin
    sel_dec          = '0;
    sel_dec[idx_nxt] = 1'b1;
  end

  // pattern captured once on entry to a position, held for the visit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_hi_q <= '0;
      sel_hi_q <= SEL_RST;
    end else if (tick) begin
      seg_hi_q <= (phase_nxt == PH_SHOW) ? seg_dec : '0;
      sel_hi_q <= sel_dec;
    end
  end

  if (COMMON_ANODE) begin : g_ca
    assign seg_o = ~seg_hi_q;
    assign sel_o = ~sel_hi_q;
  end else begin : g_cc
    assign seg_o = seg_hi_q;
    assign sel_o = sel_hi_q;
  end

  assert_sel_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(sel_hi_q));

  assert_hold_between_ticks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(seg_hi_q) && $stable(sel_hi_q));

  assert_blank_phase_dark_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_BLANK) |-> (seg_hi_q == '0));

  assert_sel_tracks_idx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_hi_q[idx]);
endmodule

// File: tb/seg_scan_top_tb_top.sv
`timescale 1ns/1ps
module seg_scan_top_tb_top;
  localparam int P = 4;
  localparam int N = 8;

  typedef struct {
    logic [7:0] seg;
    logic [7:0] sel;
    string      tag;
  } item_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_idx_i = '0;
  logic [3:0] wr_bcd_i = '0;
  logic       wr_dot_i = 1'b0;
  logic [7:0] seg_cc, sel_cc, seg_ca, sel_ca;

  int total = 0;
  int bad   = 0;

  always #10 clk_i = ~clk_i;

  seg_scan_top #(.NUM_DIGITS(N), .PRESCALE(P), .COMMON_ANODE(1'b0)) dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_bcd_i, .wr_dot_i,
    .seg_o(seg_cc), .sel_o(sel_cc)
  );

  seg_scan_top #(.NUM_DIGITS(N), .PRESCALE(P), .COMMON_ANODE(1'b1)) dut_ca_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_bcd_i, .wr_dot_i,
    .seg_o(seg_ca), .sel_o(sel_ca)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [6:0] glyph(logic [3:0] b);
    case (b)
      4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
      4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
      4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
      4'd9: return 7'h6F;  default: return 7'h00;
    endcase
  endfunction

  // scan model built from the requirements
  item_t      q[$];
  int         m_cnt;
  logic       m_show;
  int         m_idx;
  logic [3:0] sh_bcd [N];
  logic       sh_dot [N];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_show = 1'b0; m_idx = N - 1;
      for (int i = 0; i < N; i++) begin sh_bcd[i] = 4'hF; sh_dot[i] = 1'b0; end
    end else begin
      if (m_cnt == P - 1) begin
        item_t it;
        m_cnt = 0;
        if (m_show) begin
          m_show = 1'b0;
          it.seg = 8'h00; it.sel = 8'(1 << m_idx); it.tag = "R5";
        end else begin
          m_show = 1'b1;
          m_idx  = (m_idx + 1) % N;
          it.sel = 8'(1 << m_idx);
          it.seg = (sh_bcd[m_idx] > 9) ? 8'h00 : {sh_dot[m_idx], glyph(sh_bcd[m_idx])};
          if (wr_en_i && int'(wr_idx_i) == m_idx) it.tag = "R8";
          else if (sh_bcd[m_idx] > 9)            it.tag = "R4";
          else if (sh_dot[m_idx])                it.tag = "R10";
          else if (m_idx == 0)                   it.tag = "R6";
          else                                   it.tag = "R3";
        end
        q.push_back(it);
      end else begin
        m_cnt++;
      end
      if (wr_en_i) begin
        sh_bcd[wr_idx_i] = wr_bcd_i;
        sh_dot[wr_idx_i] = wr_dot_i;
      end
    end
  end

  // monitor: compare at the falling edge after each rising edge
  logic [7:0] cur_seg = 8'h00;
  logic [7:0] cur_sel = 8'h80;
  bit         mon_en  = 1'b0;

  always @(negedge clk_i) begin
    if (mon_en && rst_ni) begin
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        cur_seg = it.seg;
        cur_sel = it.sel;
        chk(it.tag, "seg", seg_cc, cur_seg);
        chk(it.tag, "sel", sel_cc, cur_sel);
        chk("R2", "sel_ones", 8'($countones(sel_cc)), 8'd1);
        chk("R9", "seg_ca", seg_ca, ~cur_seg);
        chk("R9", "sel_ca", sel_ca, ~cur_sel);
      end else begin
        chk("R7", "seg_hold", seg_cc, cur_seg);
        chk("R7", "sel_hold", sel_cc, cur_sel);
      end
    end
  end

  task automatic write_digit(int idx, logic [3:0] bcd, logic dot);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 3'(idx); wr_bcd_i = bcd; wr_dot_i = dot;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // write in the cycle whose rising edge loads the target position
  task automatic write_on_entry(logic [3:0] bcd);
    do @(negedge clk_i); while (!(m_cnt == P - 1 && !m_show));
    wr_en_i = 1'b1; wr_idx_i = 3'((m_idx + 1) % N); wr_bcd_i = bcd; wr_dot_i = 1'b0;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    chk("R1", "seg_rst", seg_cc, 8'h00);
    chk("R1", "sel_rst", sel_cc, 8'h80);
    chk("R1", "seg_rst_ca", seg_ca, 8'hFF);
    chk("R1", "sel_rst_ca", sel_ca, 8'h7F);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    // first pass: all digits still blank from reset
    repeat (2 * N * P) @(negedge clk_i);
    for (int i = 0; i < N; i++) write_digit(i, 4'(i), i == 3);
    repeat (2 * N * P + 8) @(negedge clk_i);
    write_digit(0, 4'd8, 1'b0);
    write_digit(1, 4'd9, 1'b1);
    for (int i = 2; i < N; i++) write_digit(i, 4'(8 + i), 1'b1);
    repeat (2 * N * P + 8) @(negedge clk_i);
    write_on_entry(4'd5);
    write_on_entry(4'd2);
    write_on_entry(4'd7);
    repeat (2 * N * P + 8) @(negedge clk_i);
    // write while a position is on display
    do @(negedge clk_i); while (!(m_show && m_cnt == 1));
    write_digit(m_idx, 4'd4, 1'b1);
    repeat (2 * N * P + 8) @(negedge clk_i);
    mon_en = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule